// File: doc/BRIEF.md
# Reservation Station Pool with Result-Tag Capture

This block holds a small set of waiting instructions for one class of execution unit, for example add/sub. Each cycle it can take in one newly issued instruction. For each of the two source operands, the instruction brings either a finished value or the tag of the station that will produce that value. The block places the instruction in the lowest-numbered free entry and reports that entry's index. The entry's own tag is `BASE_TAG + index`. Tag value 0 never names a producer: an operand with tag 0 carries a valid value.

Every entry watches a single result bus that carries a tag and a value. When an entry is waiting on an operand and the bus tag matches, the entry latches the value. It does this whatever the broadcast's history: a stale result is captured the same way as a current one.

Among the entries whose operands are all present and which have not yet been sent, the oldest one is presented on the dispatch output. The execution unit is assumed to accept it in that same cycle. An entry stays allocated until its own tag appears on the result bus, and then it becomes free.

Top module: `rs_pool`

## Requirements
- R1: After reset every entry is free: `free_mask` is all ones, `iss_ready` is 1, `iss_slot` is 0 and `dsp_valid` is 0.
- R2: An operand issued with tag 0 is stored as the value given. An instruction issued in cycle N is never dispatched in cycle N, and with both operands present it is dispatched in cycle N+1 with `dsp_tag` = `BASE_TAG` + slot.
- R3: An accepted issue is placed in the free entry with the lowest index, and `iss_slot` shows that index during the issue cycle.
- R4: A waiting operand whose tag matches `bus_tag` while `bus_valid` is 1 in cycle N takes `bus_val`. Its entry is not dispatched in cycle N, and the entry may dispatch from cycle N+1 with the captured value.
- R5: If an issued operand's tag equals the tag broadcast in the issue cycle, that broadcast value is captured at issue.
- R6: When several entries are ready, the one issued earliest is dispatched, whatever its index.
- R7: An entry is dispatched exactly once between its issue and its release.
- R8: An allocated entry whose own tag is broadcast in cycle N shows as free in `free_mask` from cycle N+1.
- R9: With no free entry, `iss_ready` is 0 and an issue request changes no entry.
- R10: A broadcast whose tag differs from an operand's pending tag leaves that operand waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code of the issued instruction |
| iss_a_tag | input | TAG_W | Producer tag of operand A, 0 = value valid |
| iss_a_val | input | DATA_W | Value of operand A |
| iss_b_tag | input | TAG_W | Producer tag of operand B, 0 = value valid |
| iss_b_val | input | DATA_W | Value of operand B |
| iss_ready | output | 1 | At least one entry is free; the issue is accepted |
| iss_slot | output | IDX_W | Entry that an accepted issue goes into |
| free_mask | output | NUM_ENT | One bit per entry, 1 = free |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | TAG_W | Tag of the producing station |
| bus_val | input | DATA_W | Result value |
| dsp_valid | output | 1 | An entry is dispatched this cycle |
| dsp_op | output | OP_W | Operation code of the dispatched entry |
| dsp_tag | output | TAG_W | Tag of the dispatched entry |
| dsp_a | output | DATA_W | Operand A value |
| dsp_b | output | DATA_W | Operand B value |

## Verification
Directed sequences each isolate one behaviour:
- ready-at-issue operands, which separate the issue cycle from the first dispatch cycle;
- a broadcast that captures into a waiting entry, which exposes the one-cycle capture delay;
- a non-matching tag, which must leave the entry waiting;
- a broadcast in the issue cycle itself, which tells a missed capture from the bypass;
- a pool that is full, where an issue request must be refused.

Age ordering is tried by placing a younger instruction in a lower slot than an older one. A pick by index would then choose differently from a pick by age. A long random mix of issue, capture and release traffic is then compared, cycle by cycle, with a bench model that tracks ages by issue sequence number.

// File: rtl/rs_pkg.sv
package rs_pkg;
   typedef enum logic [1:0] {
      ENT_FREE = 2'd0,
      ENT_WAIT = 2'd1,
      ENT_EXEC = 2'd2
   } ent_state_e;
endpackage

// File: rtl/rs_opnd.sv
module rs_opnd #(
   parameter int DATA_W = 16,
   parameter int TAG_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic [DATA_W-1:0] ld_val,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_val,
   output logic              rdy,
   output logic [DATA_W-1:0] val
);
   logic [TAG_W-1:0] wait_tag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy      <= 1'b0;
         wait_tag <= '0;
         val      <= '0;
      end else if (load) begin
         if (ld_tag == '0) begin
            rdy <= 1'b1;
            val <= ld_val;
         end else if (bus_valid && bus_tag == ld_tag) begin
            rdy <= 1'b1;
            val <= bus_val;
         end else begin
            rdy      <= 1'b0;
            wait_tag <= ld_tag;
            val      <= '0;
         end
      end else if (!rdy && bus_valid && bus_tag == wait_tag) begin
         rdy <= 1'b1;
         val <= bus_val;
      end
   end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
   import rs_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int TAG_W  = 3,
   parameter int OP_W   = 4,
   parameter int IDX_W  = 2,
   parameter int MY_TAG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [OP_W-1:0]   ld_op,
   input  logic [TAG_W-1:0]  ld_a_tag,
   input  logic [DATA_W-1:0] ld_a_val,
   input  logic [TAG_W-1:0]  ld_b_tag,
   input  logic [DATA_W-1:0] ld_b_val,
   input  logic [IDX_W-1:0]  ld_age,
   input  logic              go,
   input  logic              dec_age,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_val,
   output logic              busy_o,
   output logic              ready_o,
   output logic              hit_o,
   output logic [IDX_W-1:0]  age_o,
   output logic [OP_W-1:0]   op_o,
   output logic [DATA_W-1:0] a_o,
   output logic [DATA_W-1:0] b_o
);
   ent_state_e  state;
   logic [1:0]  o_rdy;
   logic [TAG_W-1:0]  o_tag [2];
   logic [DATA_W-1:0] o_ld  [2];
   logic [DATA_W-1:0] o_val [2];

   assign o_tag[0] = ld_a_tag;
   assign o_tag[1] = ld_b_tag;
   assign o_ld[0]  = ld_a_val;
   assign o_ld[1]  = ld_b_val;

   for (genvar k = 0; k < 2; k++) begin : g_opnd
      rs_opnd #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opnd (
         .clk(clk), .rst_n(rst_n), .load(load),
         .ld_tag(o_tag[k]), .ld_val(o_ld[k]),
         .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val),
         .rdy(o_rdy[k]), .val(o_val[k])
      );
   end

   assign hit_o   = bus_valid && (bus_tag == TAG_W'(MY_TAG)) && (state != ENT_FREE);
   assign busy_o  = (state != ENT_FREE);
   assign ready_o = (state == ENT_WAIT) && (&o_rdy);
   assign a_o     = o_val[0];
   assign b_o     = o_val[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ENT_FREE;
         op_o  <= '0;
         age_o <= '0;
      end else begin
         if (load) begin
            state <= ENT_WAIT;
            op_o  <= ld_op;
         end else if (hit_o) begin
            state <= ENT_FREE;
         end else if (go) begin
            state <= ENT_EXEC;
         end
         if (load)         age_o <= ld_age;
         else if (dec_age) age_o <= age_o - 1'b1;
      end
   end
endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
   parameter int NUM_ENT = 4,
   parameter int IDX_W   = 2
) (
   input  logic [NUM_ENT-1:0] free_vec,
   output logic               any_free,
   output logic [IDX_W-1:0]   free_idx
);
   always_comb begin
      free_idx = '0;
      for (int i = NUM_ENT - 1; i >= 0; i--) begin
         if (free_vec[i]) free_idx = IDX_W'(i);
      end
   end
   assign any_free = |free_vec;
endmodule

// File: rtl/rs_oldest.sv
module rs_oldest #(
   parameter int NUM_ENT = 4,
   parameter int IDX_W   = 2
) (
   input  logic [NUM_ENT-1:0]       elig,
   input  logic [NUM_ENT*IDX_W-1:0] ages,
   output logic [NUM_ENT-1:0]       win,
   output logic                     any_win,
   output logic [IDX_W-1:0]         win_idx
);
   for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
      always_comb begin
         win[i] = elig[i];
         for (int j = 0; j < NUM_ENT; j++) begin
            if (j != i && elig[j] &&
                ages[j*IDX_W +: IDX_W] < ages[i*IDX_W +: IDX_W])
               win[i] = 1'b0;
         end
      end
   end

   always_comb begin
      win_idx = '0;
      for (int i = 0; i < NUM_ENT; i++) begin
         if (win[i]) win_idx = IDX_W'(i);
      end
   end
   assign any_win = |win;
endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
   parameter int NUM_ENT  = 4,
   parameter int DATA_W   = 16,
   parameter int TAG_W    = 3,
   parameter int OP_W     = 4,
   parameter int BASE_TAG = 1,
   localparam int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               iss_valid,
   input  logic [OP_W-1:0]    iss_op,
   input  logic [TAG_W-1:0]   iss_a_tag,
   input  logic [DATA_W-1:0]  iss_a_val,
   input  logic [TAG_W-1:0]   iss_b_tag,
   input  logic [DATA_W-1:0]  iss_b_val,
   output logic               iss_ready,
   output logic [IDX_W-1:0]   iss_slot,
   output logic [NUM_ENT-1:0] free_mask,
   input  logic               bus_valid,
   input  logic [TAG_W-1:0]   bus_tag,
   input  logic [DATA_W-1:0]  bus_val,
   output logic               dsp_valid,
   output logic [OP_W-1:0]    dsp_op,
   output logic [TAG_W-1:0]   dsp_tag,
   output logic [DATA_W-1:0]  dsp_a,
   output logic [DATA_W-1:0]  dsp_b
);
   if (NUM_ENT < 2) begin : g_bad_ent
      $error("rs_pool: NUM_ENT must be at least 2");
   end
   if (BASE_TAG < 1) begin : g_bad_base
      $error("rs_pool: tag 0 is reserved, BASE_TAG must be >= 1");
   end
   if (BASE_TAG + NUM_ENT > (1 << TAG_W)) begin : g_bad_tag
      $error("rs_pool: entry tags do not fit in TAG_W");
   end

   logic [NUM_ENT-1:0]       busy, ready, hit, load, dec;
   logic [NUM_ENT-1:0]       win;
   logic [NUM_ENT*IDX_W-1:0] age_flat;
   logic [IDX_W-1:0]         age [NUM_ENT];
   logic [OP_W-1:0]          e_op [NUM_ENT];
   logic [DATA_W-1:0]        e_a [NUM_ENT];
   logic [DATA_W-1:0]        e_b [NUM_ENT];
   logic                     any_free, any_win, rel_any, iss_fire;
   logic [IDX_W-1:0]         free_idx, win_idx, rel_age, new_age;
   logic [IDX_W:0]           busy_cnt;

   assign free_mask = ~busy;

   rs_alloc #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_alloc (
      .free_vec(free_mask), .any_free(any_free), .free_idx(free_idx)
   );

   assign iss_ready = any_free;
   assign iss_slot  = free_idx;
   assign iss_fire  = iss_valid && any_free;
   assign rel_any   = |hit;

   always_comb begin
      busy_cnt = '0;
      rel_age  = '0;
      for (int i = 0; i < NUM_ENT; i++) begin
         busy_cnt = busy_cnt + {{IDX_W{1'b0}}, busy[i]};
         if (hit[i]) rel_age = age[i];
      end
   end
   assign new_age = IDX_W'(busy_cnt - {{IDX_W{1'b0}}, rel_any});

   for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
      assign load[i] = iss_fire && (free_idx == IDX_W'(i));
      assign dec[i]  = rel_any && busy[i] && (age[i] > rel_age);
      assign age_flat[i*IDX_W +: IDX_W] = age[i];

      rs_entry #(
         .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W),
         .IDX_W(IDX_W), .MY_TAG(BASE_TAG + i)
      ) u_ent (
         .clk(clk), .rst_n(rst_n), .load(load[i]),
         .ld_op(iss_op),
         .ld_a_tag(iss_a_tag), .ld_a_val(iss_a_val),
         .ld_b_tag(iss_b_tag), .ld_b_val(iss_b_val),
         .ld_age(new_age), .go(win[i]), .dec_age(dec[i]),
         .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val),
         .busy_o(busy[i]), .ready_o(ready[i]), .hit_o(hit[i]),
         .age_o(age[i]), .op_o(e_op[i]), .a_o(e_a[i]), .b_o(e_b[i])
      );
   end

   rs_oldest #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_pick (
      .elig(ready), .ages(age_flat), .win(win),
      .any_win(any_win), .win_idx(win_idx)
   );

   assign dsp_valid = any_win;
   assign dsp_op    = e_op[win_idx];
   assign dsp_a     = e_a[win_idx];
   assign dsp_b     = e_b[win_idx];
   assign dsp_tag   = TAG_W'(BASE_TAG) + TAG_W'(win_idx);
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
   parameter int NUM_ENT  = 4,
   parameter int TAG_W    = 3,
   parameter int BASE_TAG = 1,
   parameter int IDX_W    = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               iss_valid,
   input logic               iss_ready,
   input logic [IDX_W-1:0]   iss_slot,
   input logic [NUM_ENT-1:0] free_mask,
   input logic               bus_valid,
   input logic [TAG_W-1:0]   bus_tag,
   input logic               dsp_valid,
   input logic [TAG_W-1:0]   dsp_tag
);
   // R2: nothing dispatches from the slot being filled this cycle
   a_r2_no_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready) |->
         !(dsp_valid && dsp_tag == TAG_W'(BASE_TAG) + TAG_W'(iss_slot)));

   // R3: the chosen slot is allocated after the edge
   a_r3_slot_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready) |=> !free_mask[$past(iss_slot)]);

   // R7: no back-to-back dispatch of the same entry
   a_r7_single_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_valid |=> !(dsp_valid && dsp_tag == $past(dsp_tag)));

   // R9: a full pool refuses issue
   a_r9_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (free_mask == '0) |-> !iss_ready);

   for (genvar i = 0; i < NUM_ENT; i++) begin : g_rel
      // R8: own-tag broadcast frees the entry
      a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_valid && bus_tag == TAG_W'(BASE_TAG + i) && !free_mask[i])
            |=> free_mask[i]);
   end
endmodule

bind rs_pool rs_pool_chk #(
   .NUM_ENT(NUM_ENT), .TAG_W(TAG_W), .BASE_TAG(BASE_TAG), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
   .iss_slot(iss_slot), .free_mask(free_mask), .bus_valid(bus_valid),
   .bus_tag(bus_tag), .dsp_valid(dsp_valid), .dsp_tag(dsp_tag)
);

// File: tb/tb_rs_pool.sv
`timescale 1ns/100ps
module tb_rs_pool;
   localparam int N  = 4;
   localparam int DW = 16;
   localparam int TW = 3;
   localparam int OW = 4;
   localparam int BT = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          iss_valid = 1'b0;
   logic [OW-1:0] iss_op = '0;
   logic [TW-1:0] iss_a_tag = '0, iss_b_tag = '0;
   logic [DW-1:0] iss_a_val = '0, iss_b_val = '0;
   logic          iss_ready;
   logic [1:0]    iss_slot;
   logic [N-1:0]  free_mask;
   logic          bus_valid = 1'b0;
   logic [TW-1:0] bus_tag = '0;
   logic [DW-1:0] bus_val = '0;
   logic          dsp_valid;
   logic [OW-1:0] dsp_op;
   logic [TW-1:0] dsp_tag;
   logic [DW-1:0] dsp_a, dsp_b;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   rs_pool #(.NUM_ENT(N), .DATA_W(DW), .TAG_W(TW), .OP_W(OW), .BASE_TAG(BT)) dut (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
      .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
      .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
      .iss_ready(iss_ready), .iss_slot(iss_slot), .free_mask(free_mask),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val),
      .dsp_valid(dsp_valid), .dsp_op(dsp_op), .dsp_tag(dsp_tag),
      .dsp_a(dsp_a), .dsp_b(dsp_b)
   );

   // bench model, ages by issue sequence number
   bit          m_busy [N];
   bit          m_exec [N];
   bit          m_ra [N], m_rb [N];
   logic [TW-1:0] m_ta [N], m_tb [N];
   logic [DW-1:0] m_va [N], m_vb [N];
   logic [OW-1:0] m_op [N];
   int          m_seq [N];
   int          seqc = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_free();
      for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
      return -1;
   endfunction

   function automatic int exp_disp();
      int best = -1;
      for (int i = 0; i < N; i++)
         if (m_busy[i] && !m_exec[i] && m_ra[i] && m_rb[i])
            if (best < 0 || m_seq[i] < m_seq[best]) best = i;
      return best;
   endfunction

   function automatic logic [N-1:0] exp_mask();
      logic [N-1:0] m;
      for (int i = 0; i < N; i++) m[i] = !m_busy[i];
      return m;
   endfunction

   task automatic step(input bit iv, input logic [OW-1:0] op,
                       input logic [TW-1:0] at, input logic [DW-1:0] av,
                       input logic [TW-1:0] bt, input logic [DW-1:0] bv,
                       input bit bvld, input logic [TW-1:0] btag, input logic [DW-1:0] bval);
      int fs, d;
      @(negedge clk);
      iss_valid = iv; iss_op = op; iss_a_tag = at; iss_a_val = av;
      iss_b_tag = bt; iss_b_val = bv;
      bus_valid = bvld; bus_tag = btag; bus_val = bval;
      #1;
      fs = exp_free();
      d  = exp_disp();
      chk(iss_ready == (fs >= 0), "R9 iss_ready", iss_ready, fs >= 0);
      if (fs >= 0) chk(iss_slot == fs[1:0], "R3 iss_slot", iss_slot, fs);
      chk(free_mask == exp_mask(), "R8 free_mask", free_mask, exp_mask());
      chk(dsp_valid == (d >= 0), "R6 dsp_valid", dsp_valid, d >= 0);
      if (d >= 0) begin
         chk(dsp_tag == TW'(BT + d), "R6 dsp_tag", dsp_tag, BT + d);
         chk(dsp_op == m_op[d], "R2 dsp_op", dsp_op, m_op[d]);
         chk(dsp_a == m_va[d], "R4 dsp_a", dsp_a, m_va[d]);
         chk(dsp_b == m_vb[d], "R4 dsp_b", dsp_b, m_vb[d]);
      end
      // model update for the coming edge
      if (d >= 0) m_exec[d] = 1'b1;
      for (int i = 0; i < N; i++) begin
         if (bvld && m_busy[i] && !m_ra[i] && m_ta[i] == btag) begin m_ra[i] = 1'b1; m_va[i] = bval; end
         if (bvld && m_busy[i] && !m_rb[i] && m_tb[i] == btag) begin m_rb[i] = 1'b1; m_vb[i] = bval; end
      end
      for (int i = 0; i < N; i++)
         if (bvld && m_busy[i] && btag == TW'(BT + i)) m_busy[i] = 1'b0;
      if (iv && fs >= 0) begin
         m_busy[fs] = 1'b1; m_exec[fs] = 1'b0; m_op[fs] = op;
         m_seq[fs] = seqc; seqc++;
         m_ta[fs] = at; m_tb[fs] = bt;
         m_ra[fs] = (at == 0) || (bvld && btag == at);
         m_va[fs] = (at == 0) ? av : (bvld && btag == at) ? bval : '0;
         m_rb[fs] = (bt == 0) || (bvld && btag == bt);
         m_vb[fs] = (bt == 0) ? bv : (bvld && btag == bt) ? bval : '0;
      end
   endtask

   task automatic idle();
      step(1'b0, '0, '0, '0, '0, '0, 1'b0, '0, '0);
   endtask

   task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] v);
      step(1'b0, '0, '0, '0, '0, '0, 1'b1, t, v);
   endtask

   task automatic issue(input logic [OW-1:0] op, input logic [TW-1:0] at, input logic [DW-1:0] av,
                        input logic [TW-1:0] bt, input logic [DW-1:0] bv);
      step(1'b1, op, at, av, bt, bv, 1'b0, '0, '0);
   endtask

   initial begin
      #(5.0 * 150000);
      failures++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) begin
         m_busy[i] = 0; m_exec[i] = 0; m_ra[i] = 0; m_rb[i] = 0; m_seq[i] = 0;
         m_ta[i] = '0; m_tb[i] = '0; m_va[i] = '0; m_vb[i] = '0; m_op[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(free_mask == 4'hF, "R1 free_mask", free_mask, 4'hF);
      chk(iss_ready == 1'b1, "R1 iss_ready", iss_ready, 1);
      chk(iss_slot == 2'd0, "R1 iss_slot", iss_slot, 0);
      chk(dsp_valid == 1'b0, "R1 dsp_valid", dsp_valid, 0);

      // R2 ready-at-issue operands
      issue(4'd3, 3'd0, 16'h1111, 3'd0, 16'h2222);
      chk(dsp_valid == 1'b0, "R2 issue cycle", dsp_valid, 0);
      idle();
      chk(dsp_valid && dsp_tag == 3'd1 && dsp_a == 16'h1111 && dsp_b == 16'h2222,
          "R2 next cycle", {dsp_valid, dsp_tag, dsp_a}, {1'b1, 3'd1, 16'h1111});
      idle();
      chk(dsp_valid == 1'b0, "R7 no repeat", dsp_valid, 0);
      bcast(3'd1, 16'h0);
      idle();
      chk(free_mask == 4'hF, "R8 freed", free_mask, 4'hF);

      // R10 and R4: capture via bus
      issue(4'd5, 3'd6, 16'h0, 3'd0, 16'h0005);
      bcast(3'd7, 16'h0009);
      chk(dsp_valid == 1'b0, "R10 other tag", dsp_valid, 0);
      idle();
      chk(dsp_valid == 1'b0, "R10 still waiting", dsp_valid, 0);
      bcast(3'd6, 16'h0ABC);
      chk(dsp_valid == 1'b0, "R4 capture cycle", dsp_valid, 0);
      idle();
      chk(dsp_valid && dsp_a == 16'h0ABC, "R4 after capture", dsp_a, 16'h0ABC);
      bcast(3'd1, 16'h0);

      // R5 capture in issue cycle
      step(1'b1, 4'd2, 3'd5, 16'h0, 3'd0, 16'h0007, 1'b1, 3'd5, 16'h0555);
      idle();
      chk(dsp_valid && dsp_a == 16'h0555, "R5 bypass", dsp_a, 16'h0555);
      bcast(3'd1, 16'h0);

      // R6 oldest wins over lower index
      issue(4'd1, 3'd0, 16'h1, 3'd0, 16'h1);   // A slot0
      issue(4'd2, 3'd6, 16'h0, 3'd0, 16'h2);   // B slot1
      bcast(3'd1, 16'h0);                     // free A
      issue(4'd3, 3'd6, 16'h0, 3'd0, 16'h3);   // C slot0, younger
      bcast(3'd6, 16'h0066);
      idle();
      chk(dsp_valid && dsp_tag == 3'd2, "R6 older first", dsp_tag, 2);
      idle();
      chk(dsp_valid && dsp_tag == 3'd1, "R6 younger next", dsp_tag, 1);
      bcast(3'd2, 16'h0);
      bcast(3'd1, 16'h0);

      // R9 full pool
      for (int k = 0; k < N; k++) issue(4'(k), 3'd7, 16'h0, 3'd0, 16'(k));
      idle();
      chk(iss_ready == 1'b0, "R9 full", iss_ready, 0);
      issue(4'hF, 3'd0, 16'hDEAD, 3'd0, 16'hBEEF);
      chk(free_mask == 4'h0, "R9 mask", free_mask, 0);
      idle();
      chk(dsp_valid == 1'b0, "R9 no entry added", dsp_valid, 0);
      for (int k = 0; k < N; k++) bcast(3'(BT + k), 16'h0);
      idle();

      // random phase
      for (int c = 0; c < 4000; c++) begin
         bit iv, bvld;
         logic [TW-1:0] at, bt, btag;
         iv   = ($urandom_range(0, 1) == 1);
         at   = ($urandom_range(0, 1) == 1) ? 3'd0 : 3'($urandom_range(1, 7));
         bt   = ($urandom_range(0, 1) == 1) ? 3'd0 : 3'($urandom_range(1, 7));
         bvld = ($urandom_range(0, 9) < 6);
         btag = 3'($urandom_range(0, 7));
         step(iv, 4'($urandom_range(0, 15)), at, 16'($urandom), bt, 16'($urandom),
              bvld, btag, 16'($urandom));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule